// File: doc/BRIEF.md
# Prime-Field Modular Arithmetic Unit

This block is a sequential arithmetic engine for a prime field GF(p). It takes two W-bit operands `a_i` and `b_i` and a W-bit modulus `p_i`, all presented together with a two-bit operation code and a one-cycle `start_i` pulse. It then produces a W-bit result together with a single-cycle `done_o` strobe. The modulus is an ordinary input, so any odd prime below 2^W can be used without changing the hardware. Operands are expected to be already reduced (below p), and for division `b_i` must be nonzero.

The four operations are modular addition, modular subtraction, bit-serial Montgomery-form multiplication and modular division. Division is a binary extended-GCD loop steered by operand parity, and it yields A·B⁻¹ mod p. Setting A to 1 turns the division into a field inversion. All four operations run on one datapath that holds exactly three (W+2)-bit carry-propagate adders. A first multiplexer level picks each adder's inputs and a second level picks what gets written back. Both levels are steered by the operation code, the adder carries, the operand parity bits and the low bit of the shifting multiplier.

Top module: `gfp_alu`

## Requirements
- R1: With `op_i` = 2'b00 the result is (A+B) mod p, and `done_o` is high in the cycle after the first rising edge that follows the edge accepting `start_i`.
- R2: With `op_i` = 2'b01 the result is (A−B) mod p, with the same one-edge latency as R1.
- R3: With `op_i` = 2'b10 the result is A·B·2^(−W) mod p, fully reduced, and `done_o` is high after the (W+1)-th rising edge following the accepting edge.
- R4: With `op_i` = 2'b11 the result is A·B^(−1) mod p, and `done_o` arrives within 6W+2 rising edges of the accepting edge. B=1 returns A, and A=0 returns 0.
- R5: `done_o` is high for exactly one cycle per operation. `busy_o` is high from the accepting edge until the edge that raises `done_o`, and it is low while `done_o` is high.
- R6: A `start_i` pulse, with any operands and operation code, that arrives while `busy_o` is high has no effect on the running operation's result.
- R7: After reset, `busy_o`, `done_o` and `result_o` are all zero.
- R8: Any odd prime 3 ≤ p < 2^W is accepted, and every delivered result lies in [0, p).
- R9: `result_o` changes only in a cycle where `done_o` is high, and it holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request, sampled when idle |
| op_i | input | 2 | Operation: 00 add, 01 sub, 10 mul, 11 div |
| a_i | input | W | Operand A (reduced) |
| b_i | input | W | Operand B (reduced; nonzero for division) |
| p_i | input | W | Odd prime modulus |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | W | Result of the last operation |

## Verification
The bench goes after the reduction boundaries: sums that land exactly on or just past p, differences that borrow, equal operands, and products of p−1 by itself. A design that picks the wrong branch at the carry test would return a value offset by p, or one outside [0, p). For multiplication the final accumulator can fall in [p, 2p), so a missing last subtraction leaves an unreduced result. The per-clock latency check catches an off-by-one iteration count. Division is driven with B=1, A=0 and B=p−1, which exercise immediate termination, a zero numerator and the longest parity walks, along with the smallest prime, 3. A wrong parity steering or swap would yield a result whose product with B does not match A. Start pulses carrying altered operands are injected during busy cycles; a design that listened to them would corrupt the result or restart.

// File: rtl/gfp_pkg.sv
`timescale 1ns/1ps
package gfp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } gfp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } gfp_st_e;
endpackage

// File: rtl/gfp_adder.sv
`timescale 1ns/1ps
module gfp_adder #(
  parameter int N = 10
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N-1:0] b_eff;
  logic [N:0]   full;

  assign b_eff = inv_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{N{1'b0}}, cin_i};
  assign sum_o  = full[N-1:0];
  assign cout_o = full[N];
endmodule

// File: rtl/gfp_ctrl.sv
`timescale 1ns/1ps
module gfp_ctrl
  import gfp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  gfp_op_e op_q_i,
  input  logic    term_i,
  output gfp_st_e st_o,
  output logic    accept_o,
  output logic    finish_o
);
  localparam int CW = $clog2(W) + 1;

  gfp_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign st_o     = st_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    finish_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_RUN;
        cnt_d = '0;
      end
      ST_RUN: begin
        case (op_q_i)
          OP_ADD, OP_SUB: begin
            st_d     = ST_IDLE;
            finish_o = 1'b1;
          end
          OP_MUL: begin
            if (cnt_q == CW'(W - 1)) st_d = ST_FIN;
            else cnt_d = cnt_q + 1'b1;
          end
          default: if (term_i) begin
            st_d     = ST_IDLE;
            finish_o = 1'b1;
          end
        endcase
      end
      ST_FIN: begin
        st_d     = ST_IDLE;
        finish_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  fin_only_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIN) |-> (op_q_i == OP_MUL));
endmodule

// File: rtl/gfp_alu.sv
`timescale 1ns/1ps
module gfp_alu
  import gfp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] p_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int N = W + 2;
  localparam logic [N-1:0] ONE = N'(1);

  gfp_op_e      op_q;
  gfp_st_e      st;
  logic         accept, finish, term;
  logic [N-1:0] p_q, x1_q, x2_q, u_q, v_q;
  logic [W-1:0] res_q;
  logic         done_q;

  // three shared adders: operand muxes (level 1)
  logic [N-1:0] a0, b0, s0, a1, b1, s1, a2, b2, s2;
  logic         i0, c0, co0, i1, c1, co1, i2, c2, co2;

  gfp_adder #(.N(N)) u_add0 (.a_i(a0), .b_i(b0), .inv_i(i0), .cin_i(c0), .sum_o(s0), .cout_o(co0));
  gfp_adder #(.N(N)) u_add1 (.a_i(a1), .b_i(b1), .inv_i(i1), .cin_i(c1), .sum_o(s1), .cout_o(co1));
  gfp_adder #(.N(N)) u_add2 (.a_i(a2), .b_i(b2), .inv_i(i2), .cin_i(c2), .sum_o(s2), .cout_o(co2));

  assign term = (u_q == ONE) || (v_q == ONE);

  gfp_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_q_i   (op_q),
    .term_i   (term),
    .st_o     (st),
    .accept_o (accept),
    .finish_o (finish)
  );

  always_comb begin
    a0 = '0; b0 = '0; i0 = 1'b0; c0 = 1'b0;
    a1 = '0; b1 = '0; i1 = 1'b0; c1 = 1'b0;
    a2 = '0; b2 = '0; i2 = 1'b0; c2 = 1'b0;
    case (op_q)
      OP_ADD: begin
        a0 = x1_q; b0 = x2_q;
        a1 = s0;   b1 = p_q; i1 = 1'b1; c1 = 1'b1;
      end
      OP_SUB: begin
        a0 = x1_q; b0 = x2_q; i0 = 1'b1; c0 = 1'b1;
        a1 = s0;   b1 = p_q;
      end
      OP_MUL: begin
        a0 = x1_q; b0 = u_q[0] ? x2_q : '0;
        a1 = s0;   b1 = s0[0] ? p_q : '0;
        a2 = x1_q; b2 = p_q; i2 = 1'b1; c2 = 1'b1;
      end
      default: begin
        if (!u_q[0]) begin
          a0 = x1_q; b0 = p_q;
        end else if (!v_q[0]) begin
          a0 = x2_q; b0 = p_q;
        end else begin
          a0 = u_q; b0 = v_q; i0 = 1'b1; c0 = 1'b1;
        end
        a1 = x1_q; b1 = x2_q; i1 = 1'b1; c1 = 1'b1;
        a2 = s1;   b2 = p_q;
      end
    endcase
  end

  // working registers: write-back muxes (level 2)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_ADD;
      p_q  <= '0;
      x1_q <= '0;
      x2_q <= '0;
      u_q  <= '0;
      v_q  <= '0;
    end else if (accept) begin
      op_q <= gfp_op_e'(op_i);
      p_q  <= {2'b00, p_i};
      v_q  <= {2'b00, p_i};
      case (gfp_op_e'(op_i))
        OP_MUL: begin
          x1_q <= '0;
          x2_q <= {2'b00, a_i};
          u_q  <= {2'b00, b_i};
        end
        OP_DIV: begin
          x1_q <= {2'b00, a_i};
          x2_q <= '0;
          u_q  <= {2'b00, b_i};
        end
        default: begin
          x1_q <= {2'b00, a_i};
          x2_q <= {2'b00, b_i};
          u_q  <= '0;
        end
      endcase
    end else if (st == ST_RUN) begin
      case (op_q)
        OP_MUL: begin
          x1_q <= s1 >> 1;
          u_q  <= u_q >> 1;
        end
        OP_DIV: if (!term) begin
          if (!u_q[0]) begin
            u_q  <= u_q >> 1;
            x1_q <= x1_q[0] ? (s0 >> 1) : (x1_q >> 1);
          end else if (!v_q[0]) begin
            v_q  <= v_q >> 1;
            x2_q <= x2_q[0] ? (s0 >> 1) : (x2_q >> 1);
          end else if (co0) begin
            u_q  <= s0;
            x1_q <= co1 ? s1 : s2;
          end else begin
            // u < v: exchange roles, subtract on the next cycle
            u_q  <= v_q;
            v_q  <= u_q;
            x1_q <= x2_q;
            x2_q <= x1_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (st == ST_FIN) begin
        res_q <= co2 ? s2[W-1:0] : x1_q[W-1:0];
      end else if (st == ST_RUN) begin
        case (op_q)
          OP_ADD: res_q <= co1 ? s1[W-1:0] : s0[W-1:0];
          OP_SUB: res_q <= co0 ? s0[W-1:0] : s1[W-1:0];
          OP_DIV: if (term) res_q <= (u_q == ONE) ? x1_q[W-1:0] : x2_q[W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = (st != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(p_q) && $stable(op_q)));
  // R8
  res_in_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({2'b00, res_q} < p_q));
  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> done_o);
  // R3
  mul_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && op_q == OP_MUL) |-> (x1_q < (p_q << 1)));
  // R3
  fin_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FIN && co2) |-> (s2[N-1:W] == 2'b00));
  // R4
  div_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && op_q == OP_DIV) |->
      (x1_q < p_q && x2_q < p_q && u_q != '0 && v_q != '0));
endmodule

// File: tb/tb_gfp_alu.sv
`timescale 1ns/1ps
module tb_gfp_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] a = '0, b = '0, p = '0;
  logic         busy, done;
  logic [W-1:0] res;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gfp_alu #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .p_i(p),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_val(int m, int x, int y, int q);
    int r = 0;
    case (m)
      0: r = (x + y) % q;
      1: r = (x - y + q) % q;
      2: for (int t = 0; t < q; t++) if (((t << W) % q) == ((x * y) % q)) r = t;
      default: for (int t = 0; t < q; t++) if (((t * y) % q) == (x % q)) r = t;
    endcase
    return r;
  endfunction

  task automatic run_op(int m, int x, int y, int q, bit disturb, string tag);
    int got = 0;
    int lat;
    int expv;
    logic [W-1:0] held;
    expv = ref_val(m, x, y, q);
    lat  = (m < 2) ? 1 : ((m == 2) ? W + 1 : 0);
    @(negedge clk);
    op = 2'(m); a = W'(x); b = W'(y); p = W'(q); start = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R5 busy after accept", int'(busy), 1);
    if (disturb) begin
      op = ~op; a = ~a; b = b + 1'b1; p = p - 2; start = 1'b1;
    end else begin
      start = 1'b0;
    end
    for (int k = 1; k <= 6 * W + 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done === 1'b1) begin
        got = k;
        break;
      end
      chk(busy === 1'b1, "R5 busy until done", int'(busy), 1);
    end
    if (lat > 0) chk(got == lat, {tag, " latency"}, got, lat);
    else chk(got > 0, "R4 completes in bound", got, 1);
    chk(int'(res) == expv, tag, int'(res), expv);
    chk(int'(res) < q, "R8 in field", int'(res), q - 1);
    if (disturb) chk(int'(res) == expv, "R6 start while busy", int'(res), expv);
    chk(busy === 1'b0, "R5 idle with done", int'(busy), 0);
    held = res;
    @(negedge clk);
    chk(done === 1'b0, "R5 single pulse", int'(done), 0);
    chk(res == held, "R9 result held", int'(res), int'(held));
  endtask

  initial begin
    #(4 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int primes[5] = '{3, 11, 97, 251, 13};
    string tags[4] = '{"R1", "R2", "R3", "R4"};
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R7 busy reset", int'(busy), 0);
    chk(done === 1'b0, "R7 done reset", int'(done), 0);
    chk(res === '0, "R7 result reset", int'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R7 idle after reset", int'(busy), 0);

    // boundary cases
    run_op(0, 250, 250, 251, 1'b0, "R1");
    run_op(0, 125, 126, 251, 1'b0, "R1");
    run_op(0, 0, 0, 251, 1'b0, "R1");
    run_op(1, 0, 250, 251, 1'b0, "R2");
    run_op(1, 77, 77, 251, 1'b0, "R2");
    run_op(2, 250, 250, 251, 1'b0, "R3");
    run_op(2, 0, 200, 251, 1'b0, "R3");
    run_op(2, 1, 1, 251, 1'b1, "R3");
    run_op(3, 123, 1, 251, 1'b0, "R4");
    run_op(3, 0, 77, 251, 1'b0, "R4");
    run_op(3, 5, 250, 251, 1'b1, "R4");
    run_op(3, 1, 128, 251, 1'b0, "R4");
    run_op(2, 2, 2, 3, 1'b0, "R8");
    run_op(3, 2, 2, 3, 1'b0, "R8");
    run_op(1, 1, 2, 3, 1'b0, "R8");

    // random sweep over several primes
    foreach (primes[pi]) begin
      for (int m = 0; m < 4; m++) begin
        for (int i = 0; i < 6; i++) begin
          int q = primes[pi];
          int x = int'($urandom % q);
          int y = int'($urandom % q);
          if (m == 3 && y == 0) y = 1;
          run_op(m, x, y, q, (i == 2), tags[m]);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule